// File: doc/BRIEF.md
# Byte-Wide March Memory Self-Test Engine

This engine checks a window of a synchronous single-port byte memory with a fixed four-pass march. The host supplies a base address and a byte count and pulses start. The engine then owns the memory port. It first fills the window with all-ones. It then makes three ascending read, verify and invert passes, which expect all-ones, then all-zeros, then all-ones. Memory outside the window is never touched, so a host can test only the region above a boundary it is not using.

The run stops at the first mismatch. The pass number, the failing address, the expected byte and the observed byte stay available until the next start. If every element matches, the engine reports completion with no error. A run over n bytes keeps the engine busy for 10·n cycles.

Top module: `march_bist`

## Requirements
- R1: After reset, busy, done, error and mem_we are low and pass_num is 0.
- R2: A start pulse seen while idle is accepted. In the next cycle busy is high (for a non-zero count), and done, error and the captured failure fields are cleared.
- R3: Pass 1 drives one write per cycle of 0xFF, at addresses base, base+1, … base+n-1 in that order. It makes no reads.
- R4: Passes 2 to 4 each visit the window in ascending order, with three cycles per byte: a read cycle (mem_we low), a compare cycle (mem_we low, same address), then a write cycle. The write data is the bitwise inverse of the byte read. The expected bytes are 0xFF in pass 2, 0x00 in pass 3 and 0xFF in pass 4.
- R5: pass_num shows the pass in progress as a value from 1 to 4 throughout a run.
- R6: On the first mismatch the engine leaves busy after the compare cycle, raises done and error, keeps pass_num at the failing pass, and performs no further memory access.
- R7: fail_addr, fail_exp and fail_obs hold the failing address, the expected byte and the read byte. They keep these values until the next accepted start.
- R8: If pass 4 finishes with no mismatch, then done is 1, error is 0 and pass_num is 4.
- R9: A start with byte_count 0 sets done in the next cycle with error 0 and pass_num 0. It never raises busy or mem_we.
- R10: A start pulse while busy has no effect on the access sequence or the result.
- R11: No address outside [base, base+n) is written.
- R12: A mismatch on the last byte of pass 4 is reported as an error, not as success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| base_addr | input | ADDR_W | First byte of the window |
| byte_count | input | ADDR_W+1 | Window length in bytes |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | Last run finished, held until next start |
| error | output | 1 | Last run found a mismatch |
| pass_num | output | 3 | Current or failing pass, 1 to 4 |
| fail_addr | output | ADDR_W | Address of the mismatch |
| fail_exp | output | 8 | Expected byte at the mismatch |
| fail_obs | output | 8 | Byte actually read at the mismatch |

## Verification
Completion of the final pass and error capture can fall in the same cycle. This happens when the byte at the top of the window is corrupted only by its third write, so the compare on the very last element of pass 4 fails. The bench models the memory with an injectable write-disturb fault. It predicts every bus cycle behaviourally and expects error, not success, with pass 4 and the last address captured. A start pulse arriving during a run is injected in the same way and judged against an unchanged predicted sequence.

// File: rtl/march_bist.sv
module march_bist #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W:0]   byte_count,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [2:0]        pass_num,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_exp,
  output logic [7:0]        fail_obs
);
  localparam int CNT_W = ADDR_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_RD, S_CMP, S_WR} st_t;
  st_t st;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, idx;
  logic [7:0]        wr_q;
  logic              last;
  logic [7:0]        expect_b;

  assign last      = (idx + 1'b1) == cnt_q;
  assign expect_b  = pass_num[0] ? 8'h00 : 8'hFF;
  assign mem_addr  = base_q + idx[ADDR_W-1:0];
  assign mem_we    = (st == S_FILL) || (st == S_WR);
  assign mem_wdata = (st == S_FILL) ? 8'hFF : wr_q;
  assign busy      = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      cnt_q     <= '0;
      idx       <= '0;
      wr_q      <= '0;
      pass_num  <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q    <= base_addr;
          cnt_q     <= byte_count;
          idx       <= '0;
          error     <= 1'b0;
          fail_addr <= '0;
          fail_exp  <= '0;
          fail_obs  <= '0;
          if (byte_count == '0) begin
            pass_num <= 3'd0;
            done     <= 1'b1;
          end else begin
            pass_num <= 3'd1;
            done     <= 1'b0;
            st       <= S_FILL;
          end
        end
        S_FILL: begin
          if (last) begin
            idx      <= '0;
            pass_num <= 3'd2;
            st       <= S_RD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RD: st <= S_CMP;
        S_CMP: begin
          if (mem_rdata != expect_b) begin
            error     <= 1'b1;
            done      <= 1'b1;
            fail_addr <= mem_addr;
            fail_exp  <= expect_b;
            fail_obs  <= mem_rdata;
            st        <= S_IDLE;
          end else begin
            wr_q <= ~mem_rdata;
            st   <= S_WR;
          end
        end
        S_WR: begin
          if (!last) begin
            idx <= idx + 1'b1;
            st  <= S_RD;
          end else if (pass_num == 3'd4) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx      <= '0;
            pass_num <= pass_num + 3'd1;
            st       <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WRITE_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |-> (mem_wdata == ~$past(mem_rdata)));  // R4
  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pass_num >= 3'd1 && pass_num <= 3'd4));  // R5
  AST_ERR_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (fail_exp != fail_obs));  // R6
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({fail_addr, fail_exp, fail_obs, error}));  // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8
  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (CNT_W'(mem_addr - base_q) < cnt_q));  // R11
endmodule

// File: tb/march_bist_test.sv
`timescale 1ns/1ps
module march_bist_test;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0]   byte_count = '0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic          mem_we, busy, done, error;
  logic [7:0]    mem_wdata, mem_rdata, fail_exp, fail_obs;
  logic [2:0]    pass_num;

  always #5 clk = ~clk;

  march_bist #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .byte_count(byte_count), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .error(error), .pass_num(pass_num), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_obs(fail_obs));

  logic [7:0] ram [256];
  logic [7:0] f_addr = 0, f_xor = 0;
  int         f_k = 0, wcnt = 0;
  logic       prefill = 0;

  always @(posedge clk) begin
    logic [7:0] v;
    if (prefill) begin
      for (int i = 0; i < 256; i++) ram[i] <= 8'h5A;
    end else if (mem_we) begin
      v = mem_wdata;
      if (mem_addr == f_addr) begin
        wcnt = wcnt + 1;
        if (wcnt == f_k) v = v ^ f_xor;
      end
      ram[mem_addr] <= v;
    end
    if (start && !busy) wcnt = 0;
    mem_rdata <= ram[mem_addr];
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int q_we[$], q_addr[$], q_wd[$], q_pass[$];
  task automatic push(input int we, input int a, input int wd, input int p);
    q_we.push_back(we); q_addr.push_back(a); q_wd.push_back(wd); q_pass.push_back(p);
  endtask

  task automatic run(input int base, input int n, input int fa, input int fk,
                     input int fx, input int ign_at, input string tag);
    int fail = 0, fpass = 0, faddr = 0, fexp = 0, fobs = 0;
    q_we.delete(); q_addr.delete(); q_wd.delete(); q_pass.delete();
    for (int a = 0; a < n; a++) push(1, base + a, 8'hFF, 1);
    for (int p = 2; p <= 4 && !fail; p++) begin
      int e = (p == 3) ? 8'h00 : 8'hFF;
      for (int a = 0; a < n && !fail; a++) begin
        int obs = e;
        if (base + a == fa && fk == p - 1) obs = e ^ fx;
        push(0, base + a, 0, p);
        push(0, base + a, 0, p);
        if (obs != e) begin
          fail = 1; fpass = p; faddr = base + a; fexp = e; fobs = obs;
        end else push(1, base + a, (~obs) & 8'hFF, p);
      end
    end
    @(negedge clk); prefill = 1;
    @(negedge clk); prefill = 0;
    f_addr = fa[7:0]; f_k = fk; f_xor = fx[7:0];
    start = 1; base_addr = base[7:0]; byte_count = n[8:0];
    @(negedge clk); start = 0;
    chk(!error && (n == 0 ? done : !done), {tag, " R2 clear on start"}, {done, error}, n == 0);
    for (int i = 0; i < q_we.size(); i++) begin
      chk(busy === 1'b1, {tag, " R2 busy"}, busy, 1);
      chk(mem_we === q_we[i][0], {tag, " R3/R4 we"}, mem_we, q_we[i]);
      chk(mem_addr === q_addr[i][7:0], {tag, " R3/R4/R11 addr"}, mem_addr, q_addr[i]);
      if (q_we[i] != 0) chk(mem_wdata === q_wd[i][7:0], {tag, " R3/R4 wdata"}, mem_wdata, q_wd[i]);
      chk(pass_num === q_pass[i][2:0], {tag, " R5 pass"}, pass_num, q_pass[i]);
      if (i == ign_at) begin start = 1; base_addr = 8'hF0; byte_count = 9'd3; end
      @(negedge clk);
      start = 0;
    end
    chk(!busy && done && !mem_we, {tag, " R6/R8 finish"}, {busy, done, mem_we}, 3'b010);
    if (n == 0) chk(pass_num == 0 && !error, {tag, " R9 zero length"}, {pass_num, error}, 0);
    else if (!fail) chk(!error && pass_num == 4, {tag, " R8 success"}, {error, pass_num}, 4);
    else begin
      chk(error && pass_num == fpass[2:0], {tag, " R6/R12 error pass"}, pass_num, fpass);
      chk(fail_addr == faddr[7:0], {tag, " R7 fail_addr"}, fail_addr, faddr);
      chk(fail_exp == fexp[7:0] && fail_obs == fobs[7:0], {tag, " R7 exp/obs"},
          {fail_exp, fail_obs}, {fexp[7:0], fobs[7:0]});
    end
    repeat (4) begin
      @(negedge clk);
      chk(!busy && !mem_we, {tag, " R6 no further access"}, mem_we, 0);
    end
    if (fail) chk(error && fail_addr == faddr[7:0] && fail_obs == fobs[7:0],
                  {tag, " R7 hold"}, fail_addr, faddr);
    if (base > 0) chk(ram[base - 1] == 8'h5A, {tag, " R11 below"}, ram[base - 1], 8'h5A);
    chk(ram[(base + n) & 255] == 8'h5A, {tag, " R11 above"}, ram[(base + n) & 255], 8'h5A);
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !mem_we && pass_num == 0, "R1 reset", {busy, done, error, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_we, "R1 after reset", {busy, done, mem_we}, 0);
    run(10, 5, 0, 0, 0, -1, "clean");
    run(0, 1, 0, 0, 0, -1, "single");
    run(40, 7, 43, 1, 8'h10, -1, "fail_p2");
    run(60, 6, 60, 2, 8'h81, -1, "fail_p3");
    run(20, 6, 25, 3, 8'h04, -1, "R12 last_p4");
    run(30, 0, 0, 0, 0, -1, "R9 zero");
    run(80, 4, 0, 0, 0, 7, "R10 ignore");
    run(90, 5, 92, 2, 8'h01, 3, "R10 ignore_err");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule